// File: doc/BRIEF.md
# Beacon Timing Counter with Event Timers

This block keeps a 64-bit microsecond timestamp counter that advances on each `tick_us` strobe. It also holds four beacon event timers. Each timer compares its target against the counter and raises a one-cycle event pulse when the counter reaches that target. The pulse then moves the target forward by one beacon period. The four timers are:

- **Beacon (timer 0):** the next target beacon time, held in time units (TU) of 1024 ticks.
- **DMA alert (timer 1):** the DMA beacon alert, held in eighths of a TU (128 ticks).
- **Software alert (timer 2):** the software beacon alert, or the contention-free period start in station mode, also held in eighths of a TU.
- **Window end (timer 3):** the end of the announcement window, held in TU.

Software writes the four timers first and the control word last. The control word carries the beacon period, a run enable and a counter-clear toggle. Each write with the toggle bit set flips an internal clear request. A write that raises the request clears the counter at once. While the request stays raised, every later block reset clears the counter again. Software therefore writes the toggle twice to leave the request low.

There are two resets. `por_n` resets everything. `rst_n` is a block reset that keeps the counter unless a clear request is pending. Both resets assert asynchronously and are released synchronously.

Top module: `beacon_tsf_timer`

Register map (addresses on `wr_addr` / `rd_addr`):

| Address | Register | Fields |
|---|---|---|
| 0 | Beacon target | 16 bits, in TU |
| 1 | DMA alert target | 19 bits, in 1/8 TU |
| 2 | Software alert target | 25 bits, in 1/8 TU |
| 3 | Window-end target | 16 bits, in TU |
| 4 | Control | [15:0] period in TU, [16] run enable, [17] counter-clear toggle |
| 5 | Counter, low word | read only |
| 6 | Counter, high word | read only |

Reading address 4 returns the period, the enable and the current clear request in bit 17.

## Requirements
- R1: The counter advances by exactly one on each clock edge where `tick_us` is high, and holds when `tick_us` is low. Writes to addresses 5 and 6 do not change it.
- R2: A control write (address 4) with bit 17 set flips the clear request.
  - If the request was low, the counter reads 0 on the next cycle and read bit 17 becomes 1.
  - If the request was high, it drops to 0 and the counter is not cleared.
- R3: A block reset (`rst_n` low) clears the counter only while the clear request is 1. It leaves the request unchanged and zeroes the period and the enable. `por_n` clears the counter and the request.
- R4: The beacon event pulses in the first cycle the counter equals target0×1024. Reading address 0 returns target0 shifted left by 10.
- R5: The DMA and software alert events pulse in the first cycle the counter equals their target×128. The window-end event pulses in the first cycle the counter equals target3×1024.
- R6: Each event advances its target by the period in that timer's unit. TU timers add the period. Eighth-TU timers add period×8.
- R7: While the enable (control bit 16) is 0, no event pulses and no target moves, but the counter keeps running.
- R8: Timer writes keep only the low bits of each timer's width and discard the rest.
  - Timers 0 and 3 keep 16 bits.
  - Timer 1 keeps 19 bits.
  - Timer 2 keeps 25 bits.
- R9: A write to timer 3 of a value equal to the current timer-0 target stores timer0+1 instead. Any other value is stored as written.
- R10: Every event pulse lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, resets everything |
| rst_n | input | 1 | Block reset, active low, keeps the counter unless a clear is pending |
| tick_us | input | 1 | Microsecond strobe that advances the counter |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| tsf | output | 64 | Current counter value |
| evt_tbtt | output | 1 | Beacon-time event pulse |
| evt_dba | output | 1 | DMA alert event pulse |
| evt_swba | output | 1 | Software alert event pulse |
| evt_atim | output | 1 | Window-end event pulse |

## Verification
All results are due one cycle after the stimulus that causes them:

- **Register writes:** a register write taken at a rising edge is visible on the combinational read port before the next edge.
- **Counter and events:** the counter step and an event pulse are registered at the same edge. A pulse is therefore high in exactly the cycle in which `tsf` first shows the target value.
- **Block reset:** a block reset takes effect within two edges.

The bench drives inputs on falling edges and samples on the next falling edge. In the sweeps it keeps an arithmetic model of each target in ticks. Every cycle it compares each event output against "counter equals model target" and advances the model by the period when they match.

// File: rtl/beacon_tsf_pkg.sv
package beacon_tsf_pkg;
  localparam int TSF_W   = 64;
  localparam int PER_W   = 16;
  localparam int N_TMR   = 4;
  localparam int TU_SH   = 10;
  localparam int MAX_TW  = 25;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 3;

  localparam logic [ADDR_W-1:0] A_TMR0 = 3'd0;
  localparam logic [ADDR_W-1:0] A_TMR1 = 3'd1;
  localparam logic [ADDR_W-1:0] A_TMR2 = 3'd2;
  localparam logic [ADDR_W-1:0] A_TMR3 = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd4;
  localparam logic [ADDR_W-1:0] A_TSFL = 3'd5;
  localparam logic [ADDR_W-1:0] A_TSFH = 3'd6;

  localparam int CTRL_EN_BIT  = 16;
  localparam int CTRL_CLR_BIT = 17;

  function automatic int tmr_width(input int idx);
    case (idx)
      1:       return 19;
      2:       return 25;
      default: return 16;
    endcase
  endfunction

  function automatic int tmr_shift(input int idx);
    return (idx == 1 || idx == 2) ? 7 : TU_SH;
  endfunction
endpackage

// File: rtl/bt_rst_sync.sv
module bt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage <= 2'b00;
    else         stage <= {stage[0], 1'b1};
  end

  assign srst_n = stage[1];
endmodule

// File: rtl/bt_tsf_core.sv
module bt_tsf_core #(
  parameter int TSF_W = 64
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             blk_rst_n,
  input  logic             tick,
  input  logic             toggle,
  output logic [TSF_W-1:0] tsf,
  output logic [TSF_W-1:0] tsf_inc,
  output logic             clr_req
);
  logic [TSF_W-1:0] tsf_d;
  logic             req_d;
  logic             clr_now;

  assign tsf_inc = tsf + TSF_W'(1);

  always_comb begin
    req_d   = toggle ? ~clr_req : clr_req;
    clr_now = (toggle & ~clr_req) | (~blk_rst_n & clr_req);
    if (clr_now)   tsf_d = '0;
    else if (tick) tsf_d = tsf_inc;
    else           tsf_d = tsf;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      tsf     <= '0;
      clr_req <= 1'b0;
    end else begin
      tsf     <= tsf_d;
      clr_req <= req_d;
    end
  end

  AST_TSF_STEP: assert property (@(posedge clk) disable iff (!por_n)
    (tick && !toggle && blk_rst_n) |=> (tsf == $past(tsf) + TSF_W'(1))); // R1
  AST_TOGGLE_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
    (toggle && !clr_req) |=> (tsf == '0 && clr_req)); // R2
endmodule

// File: rtl/bt_event_timer.sv
module bt_event_timer #(
  parameter int W     = 16,
  parameter int SHIFT = 10,
  parameter int TSF_W = 64,
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             ld,
  input  logic [W-1:0]     ld_val,
  input  logic             tick,
  input  logic [TSF_W-1:0] tsf_inc,
  input  logic             en,
  input  logic [PER_W-1:0] period,
  output logic             fire,
  output logic [W-1:0]     target
);
  localparam int SCALE = 10 - SHIFT;

  logic         hit;
  logic [W-1:0] step;
  logic [W-1:0] target_d;

  always_comb begin
    step = W'(period) << SCALE;
    hit  = en & tick & (tsf_inc[SHIFT-1:0] == '0)
         & (tsf_inc[SHIFT+W-1:SHIFT] == target);
    if (ld)       target_d = ld_val;
    else if (hit) target_d = target + step;
    else          target_d = target;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      target <= '0;
      fire   <= 1'b0;
    end else begin
      target <= target_d;
      fire   <= hit;
    end
  end

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!arst_n)
    (!en && !ld) |=> $stable(target)); // R7
  AST_RELOAD_STEP: assert property (@(posedge clk) disable iff (!arst_n)
    (fire && !$past(ld)) |-> (target == W'($past(target) + $past(step)))); // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!arst_n)
    fire |=> !fire); // R10
endmodule

// File: rtl/beacon_tsf_timer.sv
module beacon_tsf_timer
  import beacon_tsf_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic [TSF_W-1:0]  tsf,
  output logic              evt_tbtt,
  output logic              evt_dba,
  output logic              evt_swba,
  output logic              evt_atim
);
  logic              srst_por_n, srst_blk_n;
  logic [TSF_W-1:0]  tsf_inc;
  logic              clr_req;
  logic              ctrl_wr, toggle;
  logic [PER_W-1:0]  period, period_d;
  logic              run_en, run_en_d;
  logic [MAX_TW-1:0] ld_pad  [N_TMR];
  logic [MAX_TW-1:0] tgt_pad [N_TMR];
  logic [N_TMR-1:0]  ld_vec, fire_vec;
  logic [15:0]       atim_in;

  bt_rst_sync u_sync_por (.clk(clk), .arst_n(por_n),         .srst_n(srst_por_n));
  bt_rst_sync u_sync_blk (.clk(clk), .arst_n(por_n & rst_n), .srst_n(srst_blk_n));

  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign toggle  = ctrl_wr && wr_data[CTRL_CLR_BIT];

  bt_tsf_core #(.TSF_W(TSF_W)) u_tsf (
    .clk(clk), .por_n(srst_por_n), .blk_rst_n(srst_blk_n), .tick(tick_us),
    .toggle(toggle), .tsf(tsf), .tsf_inc(tsf_inc), .clr_req(clr_req)
  );

  always_comb begin
    period_d = ctrl_wr ? wr_data[PER_W-1:0]   : period;
    run_en_d = ctrl_wr ? wr_data[CTRL_EN_BIT] : run_en;
  end

  always_ff @(posedge clk or negedge srst_blk_n) begin
    if (!srst_blk_n) begin
      period <= '0;
      run_en <= 1'b0;
    end else begin
      period <= period_d;
      run_en <= run_en_d;
    end
  end

  always_comb begin
    atim_in = wr_data[15:0];
    for (int i = 0; i < N_TMR; i++) begin
      ld_vec[i] = wr_en && (wr_addr == ADDR_W'(i));
      ld_pad[i] = MAX_TW'(wr_data[MAX_TW-1:0]);
    end
    ld_pad[3] = (atim_in == tgt_pad[0][15:0]) ? MAX_TW'(tgt_pad[0][15:0] + 16'd1)
                                              : MAX_TW'(atim_in);
  end

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    localparam int TW = tmr_width(g);
    localparam int TS = tmr_shift(g);
    logic [TW-1:0] tgt_w;
    bt_event_timer #(.W(TW), .SHIFT(TS), .TSF_W(TSF_W), .PER_W(PER_W)) u_tmr (
      .clk(clk), .arst_n(srst_blk_n), .ld(ld_vec[g]), .ld_val(ld_pad[g][TW-1:0]),
      .tick(tick_us), .tsf_inc(tsf_inc), .en(run_en), .period(period),
      .fire(fire_vec[g]), .target(tgt_w)
    );
    assign tgt_pad[g] = MAX_TW'(tgt_w);
  end

  assign evt_tbtt = fire_vec[0];
  assign evt_dba  = fire_vec[1];
  assign evt_swba = fire_vec[2];
  assign evt_atim = fire_vec[3];

  always_comb begin
    case (rd_addr)
      A_TMR0:  rd_data = REG_W'({tgt_pad[0][15:0], 10'b0});
      A_TMR1:  rd_data = REG_W'(tgt_pad[1]);
      A_TMR2:  rd_data = REG_W'(tgt_pad[2]);
      A_TMR3:  rd_data = REG_W'(tgt_pad[3]);
      A_CTRL:  rd_data = REG_W'({clr_req, run_en, period});
      A_TSFL:  rd_data = tsf[31:0];
      A_TSFH:  rd_data = tsf[63:32];
      default: rd_data = '0;
    endcase
  end

  AST_ATIM_GAP: assert property (@(posedge clk) disable iff (!srst_blk_n)
    (wr_en && wr_addr == A_TMR3) |=> ((tgt_pad[3] != tgt_pad[0]) || evt_tbtt)); // R9
endmodule

// File: tb/tb_beacon_tsf_timer.sv
module tb_beacon_tsf_timer;
  logic        clk = 1'b0;
  logic        por_n, rst_n, tick_us, wr_en;
  logic [2:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [63:0] tsf;
  logic        evt_tbtt, evt_dba, evt_swba, evt_atim;
  int          n_tests = 0;
  int          n_fail  = 0;

  always #10 clk = ~clk;

  beacon_tsf_timer dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick_us(tick_us),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .tsf(tsf), .evt_tbtt(evt_tbtt), .evt_dba(evt_dba),
    .evt_swba(evt_swba), .evt_atim(evt_atim)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_tsf();
    tick_us = 1'b0;
    wr(3'd4, 32'h2_0000);
    wr(3'd4, 32'h2_0000);
  endtask

  // R4 R5 R6 R10: per-cycle event model over one configuration
  task automatic sweep(input int t0, input int per);
    longint tgt[4];
    longint step;
    logic [3:0] ev;
    logic [31:0] d;
    int n0 = 0;
    int lim;
    clear_tsf();
    wr(3'd0, t0);
    wr(3'd1, t0 * 8 - 3);
    wr(3'd2, t0 * 8 - 5);
    wr(3'd3, t0);
    rd(3'd3, d);
    chk(d == t0 + 1, "R9 window bumped", d, t0 + 1);
    wr(3'd4, 32'h1_0000 | per);
    tgt[0] = longint'(t0) * 1024;
    tgt[1] = longint'(t0 * 8 - 3) * 128;
    tgt[2] = longint'(t0 * 8 - 5) * 128;
    tgt[3] = longint'(t0 + 1) * 1024;
    step = longint'(per) * 1024;
    lim = (t0 + 3 * per) * 1024 + 40;
    tick_us = 1'b1;
    for (int c = 0; c < lim; c++) begin
      @(negedge clk);
      ev = {evt_atim, evt_swba, evt_dba, evt_tbtt};
      for (int k = 0; k < 4; k++) begin
        if (longint'(tsf) == tgt[k]) begin
          chk(ev[k] == 1'b1, (k == 0) ? "R4 beacon event" : "R5 alert event", ev[k], 1);
          tgt[k] = tgt[k] + step;
          if (k == 0) n0++;
        end else if (ev[k]) begin
          chk(1'b0, "R10 stray or long pulse", k, longint'(tsf));
        end
      end
    end
    tick_us = 1'b0;
    rd(3'd0, d);
    chk(d == ((t0 + n0 * per) << 10), "R6 beacon target reloaded", d, (t0 + n0 * per) << 10);
  endtask

  initial begin
    logic [31:0] d, t0r;
    longint base;
    por_n = 1'b0; rst_n = 1'b0; tick_us = 1'b0; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    cycles(4);
    por_n = 1'b1; rst_n = 1'b1;
    cycles(3);
    chk(tsf == 64'd0, "R3 reset counter", tsf, 0);
    rd(3'd4, d);
    chk(d == 32'd0, "R3 reset control", d, 0);
    chk({evt_tbtt, evt_dba, evt_swba, evt_atim} == 4'd0, "R10 reset events", 0, 0);

    // R8 width masking
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, d);
    chk(d == 32'h03FF_FC00, "R8 timer0 mask", d, 32'h03FF_FC00);
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, d);
    chk(d == 32'h0007_FFFF, "R8 timer1 mask", d, 32'h0007_FFFF);
    wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, d);
    chk(d == 32'h01FF_FFFF, "R8 timer2 mask", d, 32'h01FF_FFFF);
    wr(3'd0, 32'd2);
    wr(3'd3, 32'hABCD_0007); rd(3'd3, d);
    chk(d == 32'd7, "R9 unequal window kept", d, 7);

    // R1 counting and hold
    base = longint'(tsf);
    cycles(5);
    chk(longint'(tsf) == base, "R1 hold without tick", tsf, base);
    tick_us = 1'b1; cycles(37); tick_us = 1'b0;
    chk(longint'(tsf) == base + 37, "R1 count ticks", tsf, base + 37);
    wr(3'd5, 32'h1234); wr(3'd6, 32'h1234);
    chk(longint'(tsf) == base + 37, "R1 counter not writable", tsf, base + 37);

    for (int t = 2; t <= 3; t++)
      for (int p = 1; p <= 2; p++)
        sweep(t, p);

    // R7 disabled: no events, no motion, counter runs
    rd(3'd0, t0r);
    wr(3'd4, 32'd1);
    base = longint'(tsf);
    tick_us = 1'b1;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (evt_tbtt | evt_dba | evt_swba | evt_atim)
        chk(1'b0, "R7 event while disabled", 1, 0);
    end
    tick_us = 1'b0;
    rd(3'd0, d);
    chk(d == t0r, "R7 target held", d, t0r);
    chk(longint'(tsf) == base + 3000, "R7 counter runs", tsf, base + 3000);

    // R2 / R3 clear toggle and block reset
    wr(3'd4, 32'h2_0000);
    chk(tsf == 64'd0, "R2 first toggle clears", tsf, 0);
    rd(3'd4, d);
    chk(d[17] == 1'b1, "R2 request raised", d[17], 1);
    tick_us = 1'b1; cycles(100); tick_us = 1'b0;
    rst_n = 1'b0; cycles(3); rst_n = 1'b1; cycles(3);
    chk(tsf == 64'd0, "R3 pending request clears on block reset", tsf, 0);
    rd(3'd4, d);
    chk(d == 32'h2_0000, "R3 request kept, fields zeroed", d, 32'h2_0000);
    tick_us = 1'b1; cycles(50); tick_us = 1'b0;
    wr(3'd4, 32'h2_0000);
    chk(tsf == 64'd50, "R2 second toggle keeps counter", tsf, 50);
    rd(3'd4, d);
    chk(d[17] == 1'b0, "R2 request lowered", d[17], 0);
    rst_n = 1'b0; cycles(3); rst_n = 1'b1; cycles(3);
    chk(tsf == 64'd50, "R3 block reset keeps counter", tsf, 50);
    wr(3'd4, 32'h2_0000);
    tick_us = 1'b1; cycles(20); tick_us = 1'b0;
    por_n = 1'b0; cycles(2); por_n = 1'b1; cycles(3);
    chk(tsf == 64'd0, "R3 power-on clears counter", tsf, 0);
    rd(3'd4, d);
    chk(d[17] == 1'b0, "R3 power-on clears request", d[17], 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule